// File: doc/BRIEF.md
# Serial Flash Command Front-End

This block is the target-side serial front end of a NOR-style flash device. It runs entirely on a fast system clock and treats the serial pins (select, clock, data in, pause) as asynchronous inputs. Each of these passes through a synchronizer and is then edge-detected. Serial clock mode 0 (idle low) and mode 3 (idle high) are both accepted. On the serial clock's rising edges the block assembles the opcode, a 24-bit address and data bytes. On its falling edges it shifts status bytes out.

Each complete write-class instruction is handed to a back end as a single-cycle pulse. The pulse carries the opcode, the address and the number of data bytes received. Every data byte is also passed on with its own one-cycle pulse.

The front end enforces three framing rules:
- A write-class frame counts only if select rises after a whole number of bytes.
- While the back end reports busy, only the status reads and the suspend opcode get through.
- The pause input freezes the frame, but it only takes hold or releases while the serial clock is low.

The system clock must run at least eight times the serial clock rate.

Top module: `spi_cmd_frontend`

## Requirements
- R1: An instruction starts only on a falling edge of select. Its first byte is the opcode, taken on serial clock rising edges with the most significant bit first.
- R2: Opcode 05h returns `stat_lo` and opcode 35h returns `stat_hi`. Bits go out most significant first, changing on serial clock falling edges. The selected register is re-sampled and sent again every 8 bits until select rises. `spi_miso_oe` is high only while a status byte is being driven with select low.
- R3: A write-class frame produces a command pulse only if select rises after a whole number of bytes. Address opcodes (02h, 20h, 52h, D8h) also need all three address bytes. A status read may be ended after any bit with no effect on the next frame.
- R4: If `busy` is high when the opcode byte completes, every opcode except 05h, 35h and 75h is dropped for that frame.
- R5: Accepted opcodes without address are 06h, 04h, 50h, 01h, C7h, 60h, 75h, 7Ah and B9h. Accepted opcodes with address are 02h, 20h, 52h and D8h. Any other opcode is dropped.
- R6: Frames in mode 3 (serial clock high when select falls and rises) behave exactly like frames in mode 0.
- R7: With select low and `wide_lane_en` low, a pause state is entered or left only while the serial clock is low, following the pause input. During a pause, serial clock edges and data are ignored and `spi_miso_oe` is low.
- R8: When `wide_lane_en` is high, the pause input has no effect.
- R9: After reset, no frame is accepted until select has been seen high.
- R10: `cmd_valid` is a one-cycle pulse. `cmd_addr` holds the three address bytes, the first received in bits 23:16, or zero for opcodes without address. `cmd_len` counts the bytes after the address, saturating at MAX_DATA. Each such byte also appears on `data_byte` with a one-cycle `data_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_csn | input | 1 | Serial select, active low |
| spi_clk | input | 1 | Serial clock |
| spi_mosi | input | 1 | Serial data in |
| spi_pause_n | input | 1 | Pause input, active low |
| busy | input | 1 | Back end busy flag |
| wide_lane_en | input | 1 | Disables the pause function when high |
| stat_lo | input | 8 | Status byte returned by 05h |
| stat_hi | input | 8 | Status byte returned by 35h |
| spi_miso | output | 1 | Serial data out |
| spi_miso_oe | output | 1 | Output enable for spi_miso |
| cmd_valid | output | 1 | One-cycle command pulse |
| cmd_op | output | 8 | Opcode of the command |
| cmd_addr | output | ADDR_W (24) | Address of the command |
| cmd_len | output | CNT_W (9) | Data bytes received |
| data_valid | output | 1 | One-cycle pulse per data byte |
| data_byte | output | 8 | Data byte value |

## Verification
A table of frames drives every decoded opcode in both clock modes. It mixes complete frames with frames cut off by a few bits, cut short inside the address, or sent while busy. This separates the byte-boundary rule from the address-completeness rule and from the busy filter.

Status reads in both modes check that the right register repeats across byte boundaries. A pause taken in the middle of a status read, with garbage clocks applied during it, shows whether clock edges are really ignored and whether the output resumes at the right bit. The same garbage-clock pattern, sent once with `wide_lane_en` low and once high, tells an honoured pause from an ignored one.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;

    localparam logic [7:0] OPC_WR_EN      = 8'h06;
    localparam logic [7:0] OPC_WR_DIS     = 8'h04;
    localparam logic [7:0] OPC_VOL_EN     = 8'h50;
    localparam logic [7:0] OPC_STAT_WR    = 8'h01;
    localparam logic [7:0] OPC_PROG       = 8'h02;
    localparam logic [7:0] OPC_ERASE_4K   = 8'h20;
    localparam logic [7:0] OPC_ERASE_32K  = 8'h52;
    localparam logic [7:0] OPC_ERASE_64K  = 8'hD8;
    localparam logic [7:0] OPC_ERASE_ALLA = 8'hC7;
    localparam logic [7:0] OPC_ERASE_ALLB = 8'h60;
    localparam logic [7:0] OPC_SUSPEND    = 8'h75;
    localparam logic [7:0] OPC_RESUME     = 8'h7A;
    localparam logic [7:0] OPC_SLEEP      = 8'hB9;
    localparam logic [7:0] OPC_STAT_LO    = 8'h05;
    localparam logic [7:0] OPC_STAT_HI    = 8'h35;

    typedef enum logic [1:0] {KIND_BAD, KIND_PLAIN, KIND_ADDR, KIND_STAT} op_kind_e;

    typedef enum logic [2:0] {FE_IDLE, FE_OPC, FE_ADDR, FE_DATA, FE_STAT, FE_DROP} fe_state_e;

    function automatic op_kind_e classify(input logic [7:0] opc);
        case (opc)
            OPC_WR_EN, OPC_WR_DIS, OPC_VOL_EN, OPC_STAT_WR,
            OPC_ERASE_ALLA, OPC_ERASE_ALLB, OPC_SUSPEND,
            OPC_RESUME, OPC_SLEEP:                          return KIND_PLAIN;
            OPC_PROG, OPC_ERASE_4K, OPC_ERASE_32K,
            OPC_ERASE_64K:                                  return KIND_ADDR;
            OPC_STAT_LO, OPC_STAT_HI:                       return KIND_STAT;
            default:                                        return KIND_BAD;
        endcase
    endfunction

    function automatic logic busy_pass(input logic [7:0] opc);
        return (opc == OPC_STAT_LO) || (opc == OPC_STAT_HI) || (opc == OPC_SUSPEND);
    endfunction

endpackage

// File: rtl/spi_fe_sync.sv
module spi_fe_sync #(
    parameter int              WIDTH   = 4,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] chain_q [STAGES];
    logic [WIDTH-1:0] chain_d [STAGES];

    always_comb begin
        chain_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                chain_q[i] <= RST_VAL;
            end
        end else begin
            chain_q <= chain_d;
        end
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/spi_fe_hold.sv
module spi_fe_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic sel,
    input  logic sck_lvl,
    input  logic pause_n_lvl,
    input  logic wide_en,
    output logic active
);
    logic active_d, active_q;

    always_comb begin
        if (!sel || wide_en) begin
            active_d = 1'b0;
        end else if (!sck_lvl) begin
            active_d = !pause_n_lvl;
        end else begin
            active_d = active_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) active_q <= 1'b0;
        else        active_q <= active_d;
    end

    assign active = active_q;

    // R7: pause only begins while the serial clock is low
    assert_hold_low_sck_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active_q) |-> $past(!sck_lvl));

    // R8: wide-lane mode forces the pause off
    assert_wide_lane_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wide_en |=> !active_q);
endmodule

// File: rtl/spi_fe_rx.sv
module spi_fe_rx (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       rise,
    input  logic       din,
    output logic       done,
    output logic [7:0] byte_val,
    output logic       aligned
);
    typedef struct packed {
        logic [6:0] sreg;
        logic [2:0] cnt;
        logic       done;
        logic [7:0] byte_out;
    } rx_regs_t;

    rx_regs_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        if (clr) begin
            r_d.sreg = '0;
            r_d.cnt  = '0;
        end else if (rise) begin
            r_d.sreg = {r_q.sreg[5:0], din};
            r_d.cnt  = r_q.cnt + 3'd1;
            if (r_q.cnt == 3'd7) begin
                r_d.done     = 1'b1;
                r_d.byte_out = {r_q.sreg, din};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign done     = r_q.done;
    assign byte_val = r_q.byte_out;
    assign aligned  = (r_q.cnt == 3'd0);

    // R1: a byte completes only on an accepted rising edge
    assert_byte_after_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.done |-> $past(rise));
endmodule

// File: rtl/spi_fe_tx.sv
module spi_fe_tx (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       load,
    input  logic [7:0] load_val,
    input  logic       fall,
    input  logic [7:0] reload_val,
    output logic       bit_out,
    output logic       started
);
    typedef struct packed {
        logic [7:0] sh;
        logic [2:0] cnt;
        logic       out;
        logic       started;
        logic       en;
    } tx_regs_t;

    tx_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (clr) begin
            r_d = '0;
        end else if (load) begin
            r_d.sh      = load_val;
            r_d.cnt     = '0;
            r_d.started = 1'b0;
            r_d.en      = 1'b1;
        end else if (fall && r_q.en) begin
            r_d.out     = r_q.sh[7];
            r_d.started = 1'b1;
            if (r_q.cnt == 3'd7) begin
                r_d.sh  = reload_val;
                r_d.cnt = '0;
            end else begin
                r_d.sh  = {r_q.sh[6:0], 1'b0};
                r_d.cnt = r_q.cnt + 3'd1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign bit_out = r_q.out;
    assign started = r_q.started;

    // R2: output starts only on a serial clock falling edge
    assert_start_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.started) |-> $past(fall));
endmodule

// File: rtl/spi_cmd_frontend.sv
module spi_cmd_frontend #(
    parameter int ADDR_W      = 24,
    parameter int MAX_DATA    = 256,
    parameter int SYNC_STAGES = 2,
    localparam int ADDR_BYTES = ADDR_W / 8,
    localparam int AC_W       = $clog2(ADDR_BYTES + 1),
    localparam int CNT_W      = $clog2(MAX_DATA + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_csn,
    input  logic              spi_clk,
    input  logic              spi_mosi,
    input  logic              spi_pause_n,
    input  logic              busy,
    input  logic              wide_lane_en,
    input  logic [7:0]        stat_lo,
    input  logic [7:0]        stat_hi,
    output logic              spi_miso,
    output logic              spi_miso_oe,
    output logic              cmd_valid,
    output logic [7:0]        cmd_op,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [CNT_W-1:0]  cmd_len,
    output logic              data_valid,
    output logic [7:0]        data_byte
);
    import spi_fe_pkg::*;

    // bit order of the synchronized vector: {pause_n, mosi, clk, csn}
    localparam logic [3:0] PIN_RST = 4'b1000;

    typedef struct packed {
        fe_state_e         state;
        logic [7:0]        opc;
        logic [ADDR_W-1:0] addr;
        logic [AC_W-1:0]   acnt;
        logic [CNT_W-1:0]  dcnt;
        logic              armed;
        logic              stat_hi;
        logic [3:0]        prev;
        logic              vld;
        logic              dv;
        logic [7:0]        db;
    } fe_regs_t;

    fe_regs_t r_d, r_q;

    logic [3:0] pins_s;
    logic       cs_lvl, sck_lvl, di_lvl, pause_lvl;
    logic       cs_fall, cs_rise, sck_rise, sck_fall;
    logic       hold_act, rise_g, fall_g;
    logic       rx_done, rx_aligned;
    logic [7:0] rx_byte;
    logic       tx_load, tx_bit, tx_started;
    logic [7:0] tx_load_val, tx_reload_val;
    op_kind_e   kind;

    spi_fe_sync #(.WIDTH(4), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({spi_pause_n, spi_mosi, spi_clk, spi_csn}),
        .dout (pins_s)
    );

    assign cs_lvl    = pins_s[0];
    assign sck_lvl   = pins_s[1];
    assign di_lvl    = pins_s[2];
    assign pause_lvl = pins_s[3];
    assign cs_fall   = r_q.prev[0] & ~cs_lvl;
    assign cs_rise   = ~r_q.prev[0] & cs_lvl;
    assign sck_rise  = ~r_q.prev[1] & sck_lvl;
    assign sck_fall  = r_q.prev[1] & ~sck_lvl;

    spi_fe_hold u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel        (~cs_lvl),
        .sck_lvl    (sck_lvl),
        .pause_n_lvl(pause_lvl),
        .wide_en    (wide_lane_en),
        .active     (hold_act)
    );

    assign rise_g = sck_rise & ~hold_act & ~cs_lvl;
    assign fall_g = sck_fall & ~hold_act & ~cs_lvl;

    spi_fe_rx u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (cs_lvl),
        .rise    (rise_g),
        .din     (di_lvl),
        .done    (rx_done),
        .byte_val(rx_byte),
        .aligned (rx_aligned)
    );

    assign tx_load_val   = (rx_byte == OPC_STAT_HI) ? stat_hi : stat_lo;
    assign tx_reload_val = r_q.stat_hi ? stat_hi : stat_lo;

    spi_fe_tx u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (cs_lvl),
        .load      (tx_load),
        .load_val  (tx_load_val),
        .fall      (fall_g && (r_q.state == FE_STAT)),
        .reload_val(tx_reload_val),
        .bit_out   (tx_bit),
        .started   (tx_started)
    );

    assign kind = classify(rx_byte);

    always_comb begin
        r_d      = r_q;
        r_d.vld  = 1'b0;
        r_d.dv   = 1'b0;
        r_d.prev = pins_s;
        tx_load  = 1'b0;
        if (cs_lvl) begin
            r_d.armed = 1'b1;
            if (cs_rise && rx_aligned && (r_q.state == FE_DATA)) begin
                r_d.vld = 1'b1;
            end
            r_d.state = FE_IDLE;
        end else if (cs_fall && r_q.armed) begin
            r_d.state = FE_OPC;
            r_d.addr  = '0;
            r_d.acnt  = '0;
            r_d.dcnt  = '0;
        end else if (rx_done) begin
            case (r_q.state)
                FE_OPC: begin
                    r_d.opc = rx_byte;
                    if (kind == KIND_BAD || (busy && !busy_pass(rx_byte))) begin
                        r_d.state = FE_DROP;
                    end else if (kind == KIND_STAT) begin
                        r_d.state   = FE_STAT;
                        r_d.stat_hi = (rx_byte == OPC_STAT_HI);
                        tx_load     = 1'b1;
                    end else if (kind == KIND_ADDR) begin
                        r_d.state = FE_ADDR;
                    end else begin
                        r_d.state = FE_DATA;
                    end
                end
                FE_ADDR: begin
                    r_d.addr = {r_q.addr[ADDR_W-9:0], rx_byte};
                    r_d.acnt = r_q.acnt + AC_W'(1);
                    if (r_q.acnt == AC_W'(ADDR_BYTES - 1)) begin
                        r_d.state = FE_DATA;
                    end
                end
                FE_DATA: begin
                    r_d.dv = 1'b1;
                    r_d.db = rx_byte;
                    if (r_q.dcnt != CNT_W'(MAX_DATA)) begin
                        r_d.dcnt = r_q.dcnt + CNT_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= FE_IDLE;
            r_q.prev  <= PIN_RST;
        end else begin
            r_q <= r_d;
        end
    end

    assign spi_miso    = tx_bit;
    assign spi_miso_oe = (r_q.state == FE_STAT) & tx_started & ~hold_act & ~cs_lvl;
    assign cmd_valid   = r_q.vld;
    assign cmd_op      = r_q.opc;
    assign cmd_addr    = r_q.addr;
    assign cmd_len     = r_q.dcnt;
    assign data_valid  = r_q.dv;
    assign data_byte   = r_q.db;

    // R10: command pulse lasts one cycle
    assert_pulse_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    // R3: a command follows a select rise on a byte boundary
    assert_frame_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> $past(cs_rise && rx_aligned));

    // R7: output is off while paused
    assert_quiet_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hold_act |-> !spi_miso_oe);

    // R2: output is driven only while selected
    assert_sel_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
        spi_miso_oe |-> !cs_lvl);
endmodule

// File: tb/sim_spi_cmd_frontend.sv
module sim_spi_cmd_frontend;
    localparam int H = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic spi_csn = 1'b0, spi_clk = 1'b0, spi_mosi = 1'b0, spi_pause_n = 1'b1;
    logic busy = 1'b0, wide_lane_en = 1'b0;
    logic [7:0] stat_lo = 8'hC3, stat_hi = 8'h2D;
    logic spi_miso, spi_miso_oe, cmd_valid, data_valid;
    logic [7:0] cmd_op, data_byte;
    logic [23:0] cmd_addr;
    logic [8:0] cmd_len;

    always #10 clk = ~clk;

    spi_cmd_frontend u0 (
        .clk(clk), .rst_n(rst_n), .spi_csn(spi_csn), .spi_clk(spi_clk),
        .spi_mosi(spi_mosi), .spi_pause_n(spi_pause_n), .busy(busy),
        .wide_lane_en(wide_lane_en), .stat_lo(stat_lo), .stat_hi(stat_hi),
        .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
        .data_valid(data_valid), .data_byte(data_byte)
    );

    int n_chk = 0, n_fail = 0, pulses = 0;
    logic [7:0]  last_op = '0, last_db = '0;
    logic [23:0] last_addr = '0;
    logic [8:0]  last_len = '0;
    bit done = 0;

    always @(negedge clk) begin
        if (cmd_valid) begin
            pulses++;
            last_op = cmd_op; last_addr = cmd_addr; last_len = cmd_len;
        end
        if (data_valid) last_db = data_byte;
    end

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xfer_bit(input logic b, output logic got);
        spi_clk = 1'b0; spi_mosi = b;
        wait_clk(H);
        got = spi_miso;
        spi_clk = 1'b1;
        wait_clk(H);
    endtask

    task automatic send_byte(input logic [7:0] b);
        logic g;
        for (int i = 7; i >= 0; i--) xfer_bit(b[i], g);
    endtask

    task automatic read_byte(output logic [7:0] v);
        for (int i = 7; i >= 0; i--) xfer_bit(1'b0, v[i]);
    endtask

    task automatic begin_frame(input logic m3);
        spi_clk = m3;
        wait_clk(4);
        spi_csn = 1'b0;
        wait_clk(H);
    endtask

    task automatic end_frame(input logic m3);
        if (!m3) begin
            spi_clk = 1'b0;
            wait_clk(H);
        end
        spi_csn = 1'b1;
        wait_clk(12);
    endtask

    typedef struct packed {
        logic [7:0]  opc;
        logic [3:0]  nb;
        logic [2:0]  xb;
        logic        bsy;
        logic        m3;
        logic        ev;
        logic [8:0]  ecnt;
        logic [23:0] eaddr;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{8'h06, 4'd0, 3'd0, 1'b0, 1'b0, 1'b1, 9'd0, 24'h0},
        '{8'h04, 4'd0, 3'd0, 1'b0, 1'b0, 1'b1, 9'd0, 24'h0},
        '{8'h06, 4'd0, 3'd3, 1'b0, 1'b0, 1'b0, 9'd0, 24'h0},
        '{8'h02, 4'd5, 3'd0, 1'b0, 1'b0, 1'b1, 9'd2, 24'hA0A1A2},
        '{8'h02, 4'd4, 3'd5, 1'b0, 1'b0, 1'b0, 9'd0, 24'h0},
        '{8'h20, 4'd3, 3'd0, 1'b0, 1'b1, 1'b1, 9'd0, 24'hA0A1A2},
        '{8'hD8, 4'd2, 3'd0, 1'b0, 1'b0, 1'b0, 9'd0, 24'h0},
        '{8'h52, 4'd3, 3'd0, 1'b0, 1'b1, 1'b1, 9'd0, 24'hA0A1A2},
        '{8'h01, 4'd2, 3'd0, 1'b0, 1'b0, 1'b1, 9'd2, 24'h0},
        '{8'h06, 4'd0, 3'd0, 1'b1, 1'b0, 1'b0, 9'd0, 24'h0},
        '{8'h75, 4'd0, 3'd0, 1'b1, 1'b0, 1'b1, 9'd0, 24'h0},
        '{8'hC7, 4'd0, 3'd0, 1'b0, 1'b1, 1'b1, 9'd0, 24'h0},
        '{8'h60, 4'd0, 3'd0, 1'b0, 1'b0, 1'b1, 9'd0, 24'h0},
        '{8'h33, 4'd1, 3'd0, 1'b0, 1'b0, 1'b0, 9'd0, 24'h0},
        '{8'h7A, 4'd0, 3'd0, 1'b0, 1'b0, 1'b1, 9'd0, 24'h0},
        '{8'hB9, 4'd0, 3'd0, 1'b0, 1'b1, 1'b1, 9'd0, 24'h0},
        '{8'h50, 4'd0, 3'd0, 1'b0, 1'b0, 1'b1, 9'd0, 24'h0},
        '{8'h20, 4'd3, 3'd0, 1'b1, 1'b0, 1'b0, 9'd0, 24'h0}
    };

    function automatic string tag_of(input vec_t v);
        if (v.bsy)                   return "R4 busy filter";
        if (v.m3)                    return "R6 mode 3 frame";
        if (v.xb != 0)               return "R3 byte boundary";
        if (v.opc == 8'h33)          return "R5 unknown opcode";
        if (!v.ev)                   return "R3 short address";
        return "R1 R5 decoded opcode";
    endfunction

    initial begin
        logic [7:0] rb;
        logic g;
        int p0;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);
        check("reset R2 oe low", spi_miso_oe, 0);
        check("reset R10 no pulse", pulses, 0);

        // R9: select low since reset, a full write-enable byte is ignored
        send_byte(8'h06);
        spi_clk = 1'b0; wait_clk(H);
        spi_csn = 1'b1; wait_clk(12);
        check("R9 no frame before select high", pulses, 0);

        foreach (VECS[k]) begin
            vec_t v = VECS[k];
            busy = v.bsy;
            p0 = pulses;
            begin_frame(v.m3);
            send_byte(v.opc);
            for (int b = 0; b < int'(v.nb); b++) send_byte(8'hA0 + 8'(b));
            for (int x = 0; x < int'(v.xb); x++) xfer_bit(1'b1, g);
            end_frame(v.m3);
            busy = 1'b0;
            check(tag_of(v), pulses - p0, v.ev ? 1 : 0);
            if (v.ev) begin
                check("R10 opcode", last_op, v.opc);
                check("R10 address", last_addr, v.eaddr);
                check("R10 length", last_len, v.ecnt);
                if (v.opc == 8'h02) check("R10 data byte", last_db, 8'hA4);
            end
        end

        // R2: status low register repeats, mode 0, while busy (R4 pass)
        busy = 1'b1;
        begin_frame(1'b0);
        send_byte(8'h05);
        read_byte(rb); check("R2 status lo first", rb, 8'hC3);
        check("R2 oe during read", spi_miso_oe, 1);
        read_byte(rb); check("R4 R2 status lo repeat", rb, 8'hC3);
        end_frame(1'b0);
        busy = 1'b0;
        check("R2 oe after select", spi_miso_oe, 0);

        // R6: status high register in mode 3, ended after 3 bits (R3)
        begin_frame(1'b1);
        send_byte(8'h35);
        read_byte(rb); check("R6 status hi", rb, 8'h2D);
        for (int i = 0; i < 3; i++) xfer_bit(1'b0, g);
        end_frame(1'b1);
        p0 = pulses;
        begin_frame(1'b0); send_byte(8'h06); end_frame(1'b0);
        check("R3 frame after partial read", pulses - p0, 1);

        // R7: pause in middle of a status read
        begin_frame(1'b0);
        send_byte(8'h05);
        xfer_bit(1'b0, rb[7]); xfer_bit(1'b0, rb[6]); xfer_bit(1'b0, rb[5]);
        spi_clk = 1'b0; wait_clk(H);
        spi_pause_n = 1'b0; wait_clk(6);
        check("R7 oe low in pause", spi_miso_oe, 0);
        for (int i = 0; i < 3; i++) xfer_bit(1'b1, g);
        spi_clk = 1'b0; wait_clk(H);
        spi_pause_n = 1'b1; wait_clk(6);
        for (int i = 4; i >= 0; i--) xfer_bit(1'b0, rb[i]);
        check("R7 read resumes", rb, 8'hC3);
        end_frame(1'b0);

        // R7: pause during write frame, garbage clocks ignored
        p0 = pulses;
        begin_frame(1'b0);
        send_byte(8'h06);
        spi_clk = 1'b0; wait_clk(H);
        spi_pause_n = 1'b0; wait_clk(6);
        for (int i = 0; i < 3; i++) xfer_bit(1'b1, g);
        spi_clk = 1'b0; wait_clk(H);
        spi_pause_n = 1'b1; wait_clk(6);
        end_frame(1'b0);
        check("R7 pause keeps frame aligned", pulses - p0, 1);

        // R8: same pattern with wide lanes: clocks count, frame dropped
        wide_lane_en = 1'b1;
        p0 = pulses;
        begin_frame(1'b0);
        send_byte(8'h06);
        spi_clk = 1'b0; wait_clk(H);
        spi_pause_n = 1'b0; wait_clk(6);
        for (int i = 0; i < 3; i++) xfer_bit(1'b1, g);
        spi_clk = 1'b0; wait_clk(H);
        spi_pause_n = 1'b1; wait_clk(6);
        end_frame(1'b0);
        wide_lane_en = 1'b0;
        check("R8 pause ignored", pulses - p0, 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule